// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes a three-wire stereo audio stream (bit clock, left/right word select and serial data) from an external converter or codec and turns it into parallel samples in the system clock domain. The three serial inputs are brought into the system clock domain by synchroniser stages. The bit clock is never used as a clock: its rising edges are found by edge detection on the synchronised copy, and word select and data are sampled at those edges.

Two framings are supported and selected at run time. In the I2S framing, a low word select marks the left channel and a high word select marks the right channel, and the first bit of a word comes one bit period after the word-select change. In the left-justified framing, the word-select polarity is reversed and the first bit arrives in the same bit period as the change. Words arrive MSB first. A finished word is presented with a channel flag and a single-cycle valid strobe. The sample width is a parameter, and slots that are longer or shorter than that width are handled.

Top module: `serial_audio_rx`

## Requirements
- R1: With `fmt_sel` = 0 (I2S), a low `ws_in` marks the left channel and a high `ws_in` the right channel. The MSB is the bit sampled at the second bit-clock rising edge after the word-select change.
- R2: With `fmt_sel` = 1 (left-justified), a high `ws_in` marks the left channel and a low `ws_in` the right channel. The MSB is the bit sampled at the first bit-clock rising edge after the word-select change.
- R3: `sd_in` and `ws_in` are sampled only at rising edges of `bck_in`. A change of `sd_in` while `bck_in` is high has no effect on the received samples.
- R4: Bits are assembled MSB first. The first bit of a slot lands in `smp_data[W-1]` and each later bit lands one position lower.
- R5: Each finished word is reported by `smp_valid` high for exactly one system clock cycle. In that cycle `smp_data` holds the word and `smp_right` holds the channel (0 = left, 1 = right). A word is reported at the start point of the next slot.
- R6: Bits beyond the first W in a slot are ignored.
- R7: When a slot ends after fewer than W bits, the bits not received are zero in `smp_data`.
- R8: A change of `fmt_sel` takes effect at the next word-select change. The word in progress at that point is discarded without a valid strobe, and framing from then on follows the new format.
- R9: After reset, `smp_valid`, `smp_data` and `smp_right` are 0. No word is reported until a word has started at a word-select change and then been closed by a later one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_sel | input | 1 | Framing: 0 = I2S, 1 = left-justified |
| bck_in | input | 1 | Serial bit clock, asynchronous |
| ws_in | input | 1 | Word select (left/right clock), asynchronous |
| sd_in | input | 1 | Serial data, asynchronous |
| smp_data | output | W | Received sample, MSB aligned to bit W-1 |
| smp_right | output | 1 | Channel of the sample: 0 = left, 1 = right |
| smp_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bench builds the receiver with W = 8 instead of the default 24. With that width, a 12-bit slot runs past the sample width and a 5-bit slot falls short of it, so both edge cases fit in short frames. The small width also means each format switch in both directions, and the data glitches while the bit clock is high, take only a few dozen bit periods. Each sample value is chosen so that a one-bit framing offset, a swapped channel polarity or a missing zero fill gives a different word.

// File: rtl/sarx_pkg.sv
// Shared definitions for the serial audio receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package sarx_pkg;
    // Framing selection; the encoding matches the top-level fmt_sel pin.
    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_LJ  = 1'b1
    } fmt_e;
endpackage

// File: rtl/sarx_sync.sv
// Multi-bit synchroniser: each bit passes through STAGES flops.
// Assumes: the bits are independent, slow relative to clk, and
// sampled as a group only where skew of one cycle is harmless.
module sarx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Pass the value down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/sarx_edge.sv
// Rising-edge detector on a synchronised level.
// Assumes: sig is already in the clk domain.
module sarx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic sig_q;

    // Remember the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
endmodule

// File: rtl/sarx_framer.sv
// Word framer: finds slot starts from the word-select history, shifts
// in data MSB first, and reports each word at the next slot start.
// I2S is handled by looking at word select one bit-clock rise late,
// which makes the I2S word boundary line up with the first data bit.
// Assumes: rise is high for one cycle per bit-clock rising edge and
// ws/sd are aligned with it.
module sarx_framer
    import sarx_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fmt_sel,
    input  logic         rise,
    input  logic         ws,
    input  logic         sd,
    output logic [W-1:0] word_q,
    output logic         right_q,
    output logic         valid_q
);
    localparam int CW = $clog2(W + 1);

    fmt_e         fmt_in, mode_act, mode_use;
    logic         ws_d1, ws_d2;
    logic [1:0]   hist;
    logic         hist_ok, raw_chg, switching;
    logic         eff_now, eff_prev, start, emit, new_right;
    logic         busy, slot_right;
    logic [CW-1:0] cnt;
    logic [W-1:0] sh, pos_mask;

    assign fmt_in = fmt_e'(fmt_sel);

    // Decide framing, slot start, emission and mode switch at this rise.
    always_comb begin
        hist_ok   = (hist == 2'd2);
        raw_chg   = hist_ok && (ws != ws_d1);
        switching = rise && raw_chg && (fmt_in != mode_act);
        mode_use  = raw_chg ? fmt_in : mode_act;
        eff_now   = (mode_use == FMT_I2S) ? ws_d1 : ws;
        eff_prev  = (mode_use == FMT_I2S) ? ws_d2 : ws_d1;
        start     = rise && hist_ok && (eff_now != eff_prev);
        emit      = start && busy && !switching;
        new_right = (mode_use == FMT_I2S) ? eff_now : ~eff_now;
        pos_mask  = {1'b1, {(W-1){1'b0}}} >> cnt;
    end

    // Sequential state: word-select history, assembly and output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_d1      <= 1'b0;
            ws_d2      <= 1'b0;
            hist       <= 2'd0;
            mode_act   <= fmt_in;
            busy       <= 1'b0;
            slot_right <= 1'b0;
            cnt        <= '0;
            sh         <= '0;
            word_q     <= '0;
            right_q    <= 1'b0;
            valid_q    <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (rise) begin
                ws_d1 <= ws;
                ws_d2 <= ws_d1;
                if (!hist_ok) hist <= hist + 2'd1;
                if (raw_chg) mode_act <= fmt_in;
                if (emit) begin
                    word_q  <= sh;
                    right_q <= slot_right;
                    valid_q <= 1'b1;
                end
                if (start) begin
                    busy       <= 1'b1;
                    slot_right <= new_right;
                    sh         <= {sd, {(W-1){1'b0}}};
                    cnt        <= CW'(1);
                end else if (switching) begin
                    busy <= 1'b0;
                    cnt  <= '0;
                end else if (busy && (cnt < CW'(W))) begin
                    if (sd) sh <= sh | pos_mask;
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    // R5: a report lasts exactly one system clock cycle.
    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);
    // R3: reports only follow a bit-clock rising edge.
    a_r3_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> !valid_q);
    // R9: nothing is reported unless a word was in progress.
    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !valid_q);
    // R6: the bit count never passes the sample width.
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(W));
    // R8: a format switch drops the word in progress.
    a_r8_switch_drops: assert property (@(posedge clk) disable iff (!rst_n)
        switching |=> !valid_q);
endmodule

// File: rtl/serial_audio_rx.sv
// Dual-format serial audio receiver top: synchronises the three serial
// wires, detects bit-clock rising edges and frames words.
// Assumes: bck_in is at least four times slower than clk.
module serial_audio_rx #(
    parameter int W           = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fmt_sel,
    input  logic         bck_in,
    input  logic         ws_in,
    input  logic         sd_in,
    output logic [W-1:0] smp_data,
    output logic         smp_right,
    output logic         smp_valid
);
    logic [2:0] pins_s;
    logic       bck_rise;

    sarx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bck_in, ws_in, sd_in}),
        .sync_out (pins_s)
    );

    sarx_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (pins_s[2]),
        .rise  (bck_rise)
    );

    sarx_framer #(.W(W)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt_sel (fmt_sel),
        .rise    (bck_rise),
        .ws      (pins_s[1]),
        .sd      (pins_s[0]),
        .word_q  (smp_data),
        .right_q (smp_right),
        .valid_q (smp_valid)
    );
endmodule

// File: tb/serial_audio_rx_test.sv
// Directed bench for the serial audio receiver, sample width 8.
module serial_audio_rx_test;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fmt_sel = 1'b0;
    logic          bck = 1'b0, ws = 1'b0, sd = 1'b0;
    logic [SW-1:0] smp_data;
    logic          smp_right, smp_valid;

    int   n_chk = 0, n_bad = 0;
    int   ncap = 0, run_err = 0;
    logic [SW-1:0] cap_d [16];
    logic          cap_r [16];
    logic          last_v = 1'b0;
    logic          cur_i2s = 1'b1, prev_b = 1'b0, glitch = 1'b0;

    always #4 clk = ~clk;

    serial_audio_rx #(.W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
        .bck_in(bck), .ws_in(ws), .sd_in(sd),
        .smp_data(smp_data), .smp_right(smp_right), .smp_valid(smp_valid)
    );

    // Capture reports away from the active edge; flag any strobe over one cycle.
    always @(negedge clk) begin
        if (!rst_n) begin
            ncap = 0;
            last_v = 1'b0;
        end else begin
            if (smp_valid) begin
                if (ncap < 16) begin
                    cap_d[ncap] = smp_data;
                    cap_r[ncap] = smp_right;
                end
                ncap++;
                if (last_v) run_err++;
            end
            last_v = smp_valid;
        end
    end

    task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // One bit period: ws/data change while the bit clock is low, then it rises.
    task automatic put_bit(input logic lr, input logic b);
        @(negedge clk);
        bck = 1'b0;
        ws  = lr;
        sd  = cur_i2s ? prev_b : b;
        prev_b = b;
        repeat (4) @(negedge clk);
        bck = 1'b1;
        if (glitch) begin
            repeat (2) @(negedge clk);
            sd = ~sd;
            repeat (2) @(negedge clk);
        end else begin
            repeat (4) @(negedge clk);
        end
    endtask

    // A slot of nbits: the word MSB first, padded with ones past SW.
    task automatic send_slot(input logic lr, input logic [SW-1:0] word, input int nbits);
        for (int i = 0; i < nbits; i++)
            put_bit(lr, (i < SW) ? word[SW-1-i] : 1'b1);
    endtask

    task automatic do_reset(input logic fmt);
        fmt_sel = fmt;
        cur_i2s = (fmt == 1'b0);
        prev_b = 1'b0;
        glitch = 1'b0;
        bck = 1'b0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Left then right slot, then a short slot that closes the right word.
    task automatic run_pair(input string req, input logic fmt, input logic [SW-1:0] lw,
                            input logic [SW-1:0] rw, input int nbits,
                            input logic [SW-1:0] exp_l, input logic [SW-1:0] exp_r);
        logic left_lvl;
        do_reset(fmt);
        left_lvl = fmt;
        send_slot(~left_lvl, '0, 3);
        send_slot(left_lvl, lw, nbits);
        send_slot(~left_lvl, rw, nbits);
        send_slot(left_lvl, '0, 3);
        repeat (20) @(negedge clk);
        check_val({req, " count"}, ncap, 2);
        check_val({req, " left data"}, cap_d[0], exp_l);
        check_val({req, " left flag"}, cap_r[0], 0);
        check_val({req, " right data"}, cap_d[1], exp_r);
        check_val({req, " right flag"}, cap_r[1], 1);
    endtask

    // R9: reset values and silence until a word is closed.
    task automatic t_r9_reset_quiet;
        do_reset(1'b1);
        check_val("R9 valid after reset", smp_valid, 0);
        check_val("R9 data after reset", smp_data, 0);
        check_val("R9 flag after reset", smp_right, 0);
        send_slot(1'b0, '0, 3);
        send_slot(1'b1, 8'hA5, SW);
        repeat (20) @(negedge clk);
        check_val("R9 no report before slot closes", ncap, 0);
    endtask

    // R8: LJ->I2S switch mid-word, then I2S->LJ with a word in progress.
    task automatic t_r8_switch;
        do_reset(1'b1);
        send_slot(1'b0, '0, 3);
        send_slot(1'b1, 8'hFF, 4);
        fmt_sel = 1'b0;
        send_slot(1'b1, 8'hFF, 2);
        cur_i2s = 1'b1;
        send_slot(1'b0, 8'h69, SW);
        send_slot(1'b1, 8'hC0, 3);
        fmt_sel = 1'b1;
        cur_i2s = 1'b0;
        send_slot(1'b0, 8'h1E, SW);
        send_slot(1'b1, '0, 3);
        repeat (20) @(negedge clk);
        check_val("R8 count (partials dropped)", ncap, 2);
        check_val("R8 I2S word after switch", cap_d[0], 8'h69);
        check_val("R8 I2S low ws is left", cap_r[0], 0);
        check_val("R8 LJ word after switch", cap_d[1], 8'h1E);
        check_val("R8 LJ low ws is right", cap_r[1], 1);
    endtask

    // R3: data inverted during the high half of each bit period.
    task automatic t_r3_glitch;
        do_reset(1'b0);
        send_slot(1'b1, '0, 3);
        glitch = 1'b1;
        send_slot(1'b0, 8'hC3, SW);
        send_slot(1'b1, 8'h24, SW);
        send_slot(1'b0, '0, 3);
        glitch = 1'b0;
        repeat (20) @(negedge clk);
        check_val("R3 count", ncap, 2);
        check_val("R3 left data", cap_d[0], 8'hC3);
        check_val("R3 right data", cap_d[1], 8'h24);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_r9_reset_quiet();
        run_pair("R2 R4 LJ", 1'b1, 8'hA5, 8'h3C, SW, 8'hA5, 8'h3C);
        run_pair("R1 R4 I2S", 1'b0, 8'h96, 8'h5A, SW, 8'h96, 8'h5A);
        run_pair("R6 long slot LJ", 1'b1, 8'h81, 8'h7E, 12, 8'h81, 8'h7E);
        run_pair("R6 long slot I2S", 1'b0, 8'h42, 8'hBD, 12, 8'h42, 8'hBD);
        run_pair("R7 short slot LJ", 1'b1, 8'hFF, 8'hB7, 5, 8'hF8, 8'hB0);
        t_r3_glitch();
        t_r8_switch();
        check_val("R5 strobe one cycle wide", run_err, 0);
        summary();
        $finish;
    end
endmodule